// File: doc/BRIEF.md
# Five-Source Vectored Interrupt Controller

This block is the interrupt front end of a small 8-bit processor core. Five request lines come in. One is a non-maskable trap line. Three are maskable vectored lines, called high, middle and low, whose restart numbers are 7.5, 6.5 and 5.5. The last is a general maskable request that carries no vector of its own. The block holds the global interrupt-enable flag, three per-line mask bits, a pending latch for the high line, and a serial output bit.

The core drives the block through four inputs: a set-enable strobe, a clear-enable strobe, and a configuration write strobe with an 8-bit word. A combinational status word is always available for the core to read. The core pulses `boundary` at each instruction boundary. On that edge the block picks the highest-priority eligible request and reports it for one cycle on its outputs. Vectored sources also get a 16-bit vector address. The general request gets an acknowledge pulse and no vector.

Top module: `vec_irq_ctrl`

## Requirements
- R1: A selection happens only on a clock edge where `boundary` is 1. One cycle later, `take` pulses for exactly one cycle, and only one source is granted. The fixed priority from highest to lowest is trap, high, middle, low, general.
- R2: A vectored grant sets `vec_valid`. `vec_addr` then holds the restart number times 8: 0x0024 for trap, 0x003C for high, 0x0034 for middle and 0x002C for low. When no vector is given, `vec_addr` is 0.
- R3: The trap line ignores the enable flag and all masks. It is eligible only when a rising edge has been registered and the line is still high at the boundary. If the line drops before then, the request is discarded.
- R4: A rising edge on the high line sets a pending latch. The latch stays set after the line falls. It clears when the high line is granted, or when a configuration write has bit 4 set. A clear in the same edge as a new rising edge wins.
- R5: The middle, low and general lines are level-sensitive. They count only if they are high on the boundary edge.
- R6: A configuration write with bit 3 set loads the masks from bits 2:0 (bit 0 low, bit 1 middle, bit 2 high; 1 means masked). With bit 3 clear, the masks do not change.
- R7: A configuration write with bit 6 set loads `ser_out` from bit 7. With bit 6 clear, `ser_out` does not change. Bit 5 has no effect.
- R8: The status word is laid out as follows. Bits 2:0 are the masks. Bit 3 is the enable flag. Bit 4 is the low line level and bit 5 is the middle line level. Bit 6 is the high pending latch and bit 7 is `ser_in`.
- R9: `en_set` sets the enable flag and `en_clr` clears it; when both are 1, the clear wins. Granting any maskable source clears the flag in the same edge, overriding `en_set`. A trap grant leaves the flag alone.
- R10: A maskable line is eligible only while the enable flag is 1 and, for the vectored lines, while its mask is 0.
- R11: Reset clears the enable flag, the pending latch, the trap latch, `ser_out` and all grant outputs. It sets all three masks to 1, so the status word reads 0x07 when every input is low.
- R12: A trap grant re-arms the trap edge detector. A trap line that stays high is granted only once, and a new rising edge is needed before it can be granted again.
- R13: A general-request grant raises `gen_ack` together with `take`. `vec_valid` stays 0 and no vector address is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_req | input | 1 | Non-maskable trap request |
| hi_req | input | 1 | High vectored line (edge-latched) |
| mid_req | input | 1 | Middle vectored line (level) |
| lo_req | input | 1 | Low vectored line (level) |
| gen_req | input | 1 | General non-vectored request (level) |
| ser_in | input | 1 | Serial input pin, reflected in status |
| boundary | input | 1 | Instruction boundary strobe |
| en_set | input | 1 | Set the interrupt-enable flag |
| en_clr | input | 1 | Clear the interrupt-enable flag |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_word | input | 8 | Configuration word |
| stat_word | output | 8 | Status word |
| take | output | 1 | One-cycle grant pulse |
| vec_valid | output | 1 | Vector address is valid |
| vec_addr | output | 16 | Vector address of the granted source |
| gen_ack | output | 1 | Acknowledge for the general request |
| ser_out | output | 1 | Serial output latch |

## Verification
The embedded assertions check the following on every cycle:
- no grant appears without a boundary;
- vector addresses stay in the legal set;
- a general acknowledge never carries a vector;
- a maskable grant leaves the enable flag cleared;
- masks and the serial latch hold when their enable bits are 0;
- the high pending latch and the trap latch are empty right after their own grants.

Some behaviour needs input history, and only the bench scenarios show it. These cover priority between requests that arrive together, and a high-line pulse served long after it ended. They also cover a trap edge that is discarded because the line fell, and a held trap that is granted only once. The bench's behavioural model, compared on every clock under random stimulus, covers the interplay of enable strobes, mask writes and grants landing on the same edge.

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter logic [15:0] VEC_TRAP = 16'h0024,
  parameter logic [15:0] VEC_HI   = 16'h003C,
  parameter logic [15:0] VEC_MID  = 16'h0034,
  parameter logic [15:0] VEC_LO   = 16'h002C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trap_req,
  input  logic        hi_req,
  input  logic        mid_req,
  input  logic        lo_req,
  input  logic        gen_req,
  input  logic        ser_in,
  input  logic        boundary,
  input  logic        en_set,
  input  logic        en_clr,
  input  logic        cfg_we,
  input  logic [7:0]  cfg_word,
  output logic [7:0]  stat_word,
  output logic        take,
  output logic        vec_valid,
  output logic [15:0] vec_addr,
  output logic        gen_ack,
  output logic        ser_out
);

  logic       ie;
  logic [2:0] msk;
  logic       hi_pend, hi_prev;
  logic       trap_prev, trap_lat;

  wire trap_ok = trap_lat & trap_req;
  wire hi_ok   = ie & hi_pend & ~msk[2];
  wire mid_ok  = ie & mid_req & ~msk[1];
  wire lo_ok   = ie & lo_req  & ~msk[0];
  wire gen_ok  = ie & gen_req;

  logic [4:0]  win;
  logic [15:0] win_vec;

  always_comb begin
    win     = 5'b0;
    win_vec = 16'h0000;
    if (trap_ok)     begin win[4] = 1'b1; win_vec = VEC_TRAP; end
    else if (hi_ok)  begin win[3] = 1'b1; win_vec = VEC_HI;   end
    else if (mid_ok) begin win[2] = 1'b1; win_vec = VEC_MID;  end
    else if (lo_ok)  begin win[1] = 1'b1; win_vec = VEC_LO;   end
    else if (gen_ok)       win[0] = 1'b1;
  end

  wire grant      = boundary & (|win);
  wire trap_grant = grant & win[4];
  wire hi_grant   = grant & win[3];
  wire mask_grant = grant & ~win[4];
  wire sw_hi_clr  = cfg_we & cfg_word[4];

  assign stat_word = {ser_in, hi_pend, mid_req, lo_req, ie, msk};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie        <= 1'b0;
      msk       <= 3'b111;
      hi_pend   <= 1'b0;
      hi_prev   <= 1'b0;
      trap_prev <= 1'b0;
      trap_lat  <= 1'b0;
      ser_out   <= 1'b0;
      take      <= 1'b0;
      vec_valid <= 1'b0;
      vec_addr  <= 16'h0000;
      gen_ack   <= 1'b0;
    end else begin
      trap_prev <= trap_req;
      hi_prev   <= hi_req;

      if (trap_grant || !trap_req)    trap_lat <= 1'b0;
      else if (!trap_prev)            trap_lat <= 1'b1;

      if (hi_grant || sw_hi_clr)      hi_pend <= 1'b0;
      else if (hi_req && !hi_prev)    hi_pend <= 1'b1;

      if (mask_grant || en_clr)       ie <= 1'b0;
      else if (en_set)                ie <= 1'b1;

      if (cfg_we && cfg_word[3])      msk <= cfg_word[2:0];
      if (cfg_we && cfg_word[6])      ser_out <= cfg_word[7];

      take      <= grant;
      vec_valid <= grant & ~win[0];
      gen_ack   <= grant & win[0];
      vec_addr  <= grant ? win_vec : 16'h0000;
    end
  end

  a_r1_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> !take);
  a_r2_legal_vector: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (take && (vec_addr == VEC_TRAP || vec_addr == VEC_HI ||
                            vec_addr == VEC_MID  || vec_addr == VEC_LO)));
  a_r4_hi_pend_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_addr == VEC_HI) |-> !hi_pend);
  a_r6_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_word[3]) |=> $stable(msk));
  a_r7_ser_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_word[6]) |=> $stable(ser_out));
  a_r9_auto_disable: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_ack || (vec_valid && vec_addr != VEC_TRAP)) |-> !ie);
  a_r12_trap_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_addr == VEC_TRAP) |-> !trap_lat);
  a_r13_no_vector: assert property (@(posedge clk) disable iff (!rst_n)
    gen_ack |-> (take && !vec_valid && vec_addr == 16'h0000));

endmodule

// File: tb/vec_irq_ctrl_test.sv
module vec_irq_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap_req = 0, hi_req = 0, mid_req = 0, lo_req = 0, gen_req = 0, ser_in = 0;
  logic boundary = 0, en_set = 0, en_clr = 0, cfg_we = 0;
  logic [7:0]  cfg_word = 8'h00;
  logic [7:0]  stat_word;
  logic        take, vec_valid, gen_ack, ser_out;
  logic [15:0] vec_addr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  vec_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .hi_req(hi_req),
    .mid_req(mid_req), .lo_req(lo_req), .gen_req(gen_req), .ser_in(ser_in),
    .boundary(boundary), .en_set(en_set), .en_clr(en_clr), .cfg_we(cfg_we),
    .cfg_word(cfg_word), .stat_word(stat_word), .take(take),
    .vec_valid(vec_valid), .vec_addr(vec_addr), .gen_ack(gen_ack),
    .ser_out(ser_out)
  );

  // behavioural reference model
  bit m_ie, m_p75, m_sod, m_tlast, m_tarm, m_hlast, m_take, m_vv, m_ga;
  bit [2:0] m_msk;
  int m_addr;
  int who;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ie = 0; m_msk = 3'b111; m_p75 = 0; m_sod = 0; m_tlast = 0; m_tarm = 0;
      m_hlast = 0; m_take = 0; m_vv = 0; m_ga = 0; m_addr = 0;
    end else begin
      who = -1;
      if (boundary) begin
        if (m_tarm && trap_req) who = 0;
        else if (m_ie && m_p75 && !m_msk[2]) who = 1;
        else if (m_ie && mid_req && !m_msk[1]) who = 2;
        else if (m_ie && lo_req && !m_msk[0]) who = 3;
        else if (m_ie && gen_req) who = 4;
      end
      m_take = (who >= 0);
      m_vv   = (who >= 0 && who <= 3);
      m_ga   = (who == 4);
      case (who)
        0: m_addr = 36; 1: m_addr = 60; 2: m_addr = 52; 3: m_addr = 44;
        default: m_addr = 0;
      endcase
      if (trap_req && !m_tlast) m_tarm = 1;
      if (who == 0 || !trap_req) m_tarm = 0;
      if (hi_req && !m_hlast) m_p75 = 1;
      if (who == 1 || (cfg_we && cfg_word[4])) m_p75 = 0;
      if (en_set) m_ie = 1;
      if (en_clr || (who >= 1)) m_ie = 0;
      if (cfg_we && cfg_word[3]) m_msk = cfg_word[2:0];
      if (cfg_we && cfg_word[6]) m_sod = cfg_word[7];
      m_tlast = trap_req;
      m_hlast = hi_req;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk("R8 status word", {8'h00, stat_word},
        {8'h00, ser_in, m_p75, mid_req, lo_req, m_ie, m_msk});
    chk("R1 take", {15'h0, take}, {15'h0, m_take});
    chk("R2 vector", vec_addr, m_addr[15:0]);
    chk("R2 vec_valid", {15'h0, vec_valid}, {15'h0, m_vv});
    chk("R13 general ack", {15'h0, gen_ack}, {15'h0, m_ga});
    chk("R7 serial out", {15'h0, ser_out}, {15'h0, m_sod});
  endtask

  task automatic cfg(input logic [7:0] w);
    cfg_we = 1; cfg_word = w; tick(); cfg_we = 0; cfg_word = 8'h00;
  endtask

  task automatic enable();
    en_set = 1; tick(); en_set = 0;
  endtask

  task automatic bnd();
    boundary = 1; tick(); boundary = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    chk("R11 reset status", {8'h00, stat_word}, 16'h0007);
    chk("R11 reset take", {15'h0, take}, 16'h0000);
    rst_n = 1;
    tick();

    // R10: masked and disabled lines ignored
    lo_req = 1; mid_req = 1; gen_req = 1; bnd();
    chk("R10 no grant while disabled", {15'h0, take}, 16'h0000);
    lo_req = 0; mid_req = 0; gen_req = 0;

    // R6: mask write without enable bit
    cfg(8'h30); chk("R6 masks held", {13'h0, stat_word[2:0]}, 16'h0007);
    cfg(8'h08); chk("R6 masks loaded", {13'h0, stat_word[2:0]}, 16'h0000);

    // R5, R9: level low line
    enable(); chk("R9 enable set", {15'h0, stat_word[3]}, 16'h0001);
    lo_req = 1; bnd(); lo_req = 0;
    chk("R5 low vector", vec_addr, 16'h002C);
    chk("R9 auto disable", {15'h0, stat_word[3]}, 16'h0000);
    tick(); chk("R1 one-cycle pulse", {15'h0, take}, 16'h0000);

    // R1 priority mid over low over general
    enable(); mid_req = 1; lo_req = 1; gen_req = 1; bnd();
    chk("R1 middle wins", vec_addr, 16'h0034);
    mid_req = 0; lo_req = 0; gen_req = 0;

    // R5: level dropped before boundary is not seen
    enable(); mid_req = 1; tick(); mid_req = 0; bnd();
    chk("R5 level gone", {15'h0, take}, 16'h0000);

    // R4: short pulse latched, served later
    hi_req = 1; tick(); hi_req = 0; tick();
    chk("R4 pending visible", {15'h0, stat_word[6]}, 16'h0001);
    lo_req = 1; bnd(); lo_req = 0;
    chk("R4 high beats low", vec_addr, 16'h003C);
    chk("R4 pending cleared", {15'h0, stat_word[6]}, 16'h0000);

    // R4 software clear
    hi_req = 1; tick(); hi_req = 0; cfg(8'h10);
    chk("R4 software clear", {15'h0, stat_word[6]}, 16'h0000);

    // R13 general with masked high pending
    hi_req = 1; tick(); hi_req = 0; cfg(8'h0C); enable();
    gen_req = 1; bnd(); gen_req = 0;
    chk("R13 gen ack", {15'h0, gen_ack}, 16'h0001);
    chk("R13 no vector", {15'h0, vec_valid}, 16'h0000);
    chk("R10 masked pending kept", {15'h0, stat_word[6]}, 16'h0001);
    cfg(8'h18);

    // R3 trap with flag clear and masks set
    cfg(8'h0F); trap_req = 1; tick(); bnd();
    chk("R3 trap vector", vec_addr, 16'h0024);
    // R12 held trap not re-granted
    bnd(); chk("R12 no refire", {15'h0, take}, 16'h0000);
    trap_req = 0; tick();
    // R3 trap edge then drop
    trap_req = 1; tick(); trap_req = 0; bnd();
    chk("R3 dropped trap ignored", {15'h0, take}, 16'h0000);

    // R7 serial latch
    cfg(8'hC0); chk("R7 ser set", {15'h0, ser_out}, 16'h0001);
    cfg(8'h80); chk("R7 ser held", {15'h0, ser_out}, 16'h0001);
    cfg(8'h40); chk("R7 ser cleared", {15'h0, ser_out}, 16'h0000);

    // R9 clear wins over set; R8 serial input bit
    en_set = 1; en_clr = 1; ser_in = 1; tick(); en_set = 0; en_clr = 0;
    chk("R9 clear wins", {15'h0, stat_word[3]}, 16'h0000);
    chk("R8 serial in bit", {15'h0, stat_word[7]}, 16'h0001);

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      trap_req = ($urandom_range(0, 9) == 0) ? ~trap_req : trap_req;
      hi_req   = $urandom_range(0, 3) == 0;
      mid_req  = $urandom_range(0, 4) == 0;
      lo_req   = $urandom_range(0, 3) == 0;
      gen_req  = $urandom_range(0, 2) == 0;
      ser_in   = $urandom_range(0, 1) == 1;
      boundary = $urandom_range(0, 2) == 0;
      en_set   = $urandom_range(0, 3) == 0;
      en_clr   = $urandom_range(0, 9) == 0;
      cfg_we   = $urandom_range(0, 7) == 0;
      cfg_word = 8'($urandom_range(0, 255));
      tick();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule